// File: doc/BRIEF.md
# USB Interrupt Status and Enable Logic

This block turns the single-cycle event pulses of a USB controller into one level-sensitive interrupt request for the processor. Each accepted event sets a sticky bit in a nine-bit status register. The bit stays set until software clears it by writing one to it. A nine-bit enable register masks the status bits. The interrupt line is the registered OR of all status bits that are both set and enabled. Status bits latch whether or not they are enabled, so software can poll them instead of taking the interrupt.

Transfer completion and transaction errors are linked through the interrupt-on-complete flag of the finishing descriptor. A short packet always counts as a completion. In device mode, an error is accepted only when it reports resume signalling. The sleep bit sets on every change of the suspend-state input, in either direction, rather than on one edge.

Both registers sit on a plain 32-bit select/write bus. Read data is combinational while the block is selected for a read and is zero at any other time.

Top module: `usb_irq_ctrl`

## Requirements
- R1: When a status bit and its enable bit are both one at a clock edge, `irq` is one from the next edge onward. `irq` comes straight from a register.
- R2: A status bit sets and reads back as one even when its enable bit is zero, and `irq` then stays low.
- R3: The status register is at offset 0x00. Writing one to a bit clears it at the write edge. Writing zero to a bit leaves it unchanged.
- R4: Status bit 0 (completion) sets when `ev_xfer_done` and `ev_ioc` are high together. `ev_xfer_done` alone sets nothing.
- R5: A pulse on `ev_short_pkt` sets status bit 0.
- R6: An accepted transaction error sets status bit 1. If `ev_ioc` is high in the same cycle, bit 0 also sets in that same edge.
- R7: When `device_mode` is high, an error sets no bit unless `ev_err_resume` is high with it.
- R8: The enable register is at offset 0x04 and resets to zero. It holds bits 0 to 8 with this meaning, from bit 0 upward: completion, error, port change, frame rollover, system error, async advance, bus reset received, SOF received, sleep. The status register uses the same bit positions. Bits 31 to 9 of both registers read as zero and ignore writes.
- R9: Every transition of `suspend_state`, from 0 to 1 or from 1 to 0, sets status bit 8 one edge later.
- R10: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R11: `irq` falls one edge after the last set and enabled status bit is cleared, or one edge after its enable bit is written to zero.
- R12: Pulses on `ev_port_chg`, `ev_frame_roll`, `ev_sys_err`, `ev_async_adv`, `ev_bus_reset` and `ev_sof` set status bits 2, 3, 4, 5, 6 and 7 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| device_mode | input | 1 | High when the controller runs as a device |
| ev_xfer_done | input | 1 | Transfer finished (pulse) |
| ev_ioc | input | 1 | Interrupt-on-complete flag of the finishing descriptor |
| ev_short_pkt | input | 1 | Fewer bytes received than expected (pulse) |
| ev_xact_err | input | 1 | Transaction ended in error (pulse) |
| ev_err_resume | input | 1 | The error is resume signalling |
| ev_port_chg | input | 1 | Port change event (pulse) |
| ev_frame_roll | input | 1 | Frame index rollover (pulse) |
| ev_sys_err | input | 1 | System error (pulse) |
| ev_async_adv | input | 1 | Async schedule advance (pulse) |
| ev_bus_reset | input | 1 | Bus reset received (pulse) |
| ev_sof | input | 1 | Start-of-frame received (pulse) |
| suspend_state | input | 1 | Current device suspend state (level) |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, the status register at 0x00 and the enable register at 0x04, on a 32-bit data path. With a 32-bit path, the bench can write ones into bits 31 to 9 and confirm that they read back as zero. With the default offsets, it can interleave clears, enable updates and event pulses cycle by cycle. This brings within reach the same-cycle collision between an event and a clear, and the one-cycle lag of `irq` when it rises and when it falls.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int STAT_W     = 9;
  localparam int B_DONE     = 0;
  localparam int B_ERR      = 1;
  localparam int B_PORT     = 2;
  localparam int B_FRAME    = 3;
  localparam int B_SYSERR   = 4;
  localparam int B_ASYNC    = 5;
  localparam int B_BUSRST   = 6;
  localparam int B_SOF      = 7;
  localparam int B_SLEEP    = 8;

  typedef struct packed {
    logic xfer_done;
    logic ioc;
    logic short_pkt;
    logic xact_err;
    logic err_resume;
    logic port_chg;
    logic frame_roll;
    logic sys_err;
    logic async_adv;
    logic bus_reset;
    logic sof;
  } usb_ev_t;

  // An error counts in host mode; in device mode only resume signalling counts.
  function automatic logic err_accepted(input logic dev, input logic err, input logic resume);
    return err & (~dev | resume);
  endfunction

  // Event pulses plus suspend transition mapped onto status bit positions.
  function automatic logic [STAT_W-1:0] map_events(input usb_ev_t e, input logic dev,
                                                   input logic susp_edge);
    logic [STAT_W-1:0] s;
    logic err_ok;
    err_ok      = err_accepted(dev, e.xact_err, e.err_resume);
    s           = '0;
    s[B_DONE]   = (e.xfer_done & e.ioc) | e.short_pkt | (err_ok & e.ioc);
    s[B_ERR]    = err_ok;
    s[B_PORT]   = e.port_chg;
    s[B_FRAME]  = e.frame_roll;
    s[B_SYSERR] = e.sys_err;
    s[B_ASYNC]  = e.async_adv;
    s[B_BUSRST] = e.bus_reset;
    s[B_SOF]    = e.sof;
    s[B_SLEEP]  = susp_edge;
    return s;
  endfunction

  // Sticky bit: a new event outranks a clear in the same cycle.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/usb_irq_evmap.sv
module usb_irq_evmap
  import usb_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  usb_ev_t           ev,
  input  logic              device_mode,
  input  logic              suspend_state,
  output logic [STAT_W-1:0] set_vec
);
  logic susp_q;
  logic susp_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) susp_q <= 1'b0;
    else        susp_q <= suspend_state;
  end

  assign susp_edge = suspend_state ^ susp_q;
  assign set_vec   = map_events(ev, device_mode, susp_edge);
endmodule

// File: rtl/usb_irq_regs.sv
module usb_irq_regs
  import usb_irq_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] EN_OFS   = ADDR_W'(4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] en_q,
  output logic [STAT_W-1:0] clr_vec
);
  logic              wr_stat;
  logic              wr_en;
  logic              rd_stat;
  logic              rd_en;
  logic [STAT_W-1:0] stat_nxt;

  assign wr_stat = bus_sel & bus_wr & (bus_addr == STAT_OFS);
  assign wr_en   = bus_sel & bus_wr & (bus_addr == EN_OFS);
  assign rd_stat = bus_sel & ~bus_wr & (bus_addr == STAT_OFS);
  assign rd_en   = bus_sel & ~bus_wr & (bus_addr == EN_OFS);
  assign clr_vec = wr_stat ? bus_wdata[STAT_W-1:0] : '0;

  for (genvar i = 0; i < STAT_W; i++) begin : g_cell
    assign stat_nxt[i] = sticky_next(stat_q[i], set_vec[i], clr_vec[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_nxt;
      if (wr_en) en_q <= bus_wdata[STAT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_stat)    bus_rdata = DATA_W'(stat_q);
    else if (rd_en) bus_rdata = DATA_W'(en_q);
  end
endmodule

// File: rtl/usb_irq_out.sv
module usb_irq_out
  import usb_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_q,
  input  logic [STAT_W-1:0] en_q,
  output logic              irq
);
  logic pending;

  assign pending = |(stat_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pending;
  end
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] EN_OFS   = ADDR_W'(4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              device_mode,
  input  logic              ev_xfer_done,
  input  logic              ev_ioc,
  input  logic              ev_short_pkt,
  input  logic              ev_xact_err,
  input  logic              ev_err_resume,
  input  logic              ev_port_chg,
  input  logic              ev_frame_roll,
  input  logic              ev_sys_err,
  input  logic              ev_async_adv,
  input  logic              ev_bus_reset,
  input  logic              ev_sof,
  input  logic              suspend_state,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  usb_ev_t           ev;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] en_q;

  assign ev = '{xfer_done: ev_xfer_done, ioc: ev_ioc, short_pkt: ev_short_pkt,
                xact_err: ev_xact_err, err_resume: ev_err_resume,
                port_chg: ev_port_chg, frame_roll: ev_frame_roll,
                sys_err: ev_sys_err, async_adv: ev_async_adv,
                bus_reset: ev_bus_reset, sof: ev_sof};

  usb_irq_evmap u_evmap (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev            (ev),
    .device_mode   (device_mode),
    .suspend_state (suspend_state),
    .set_vec       (set_vec)
  );

  usb_irq_regs #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .STAT_OFS (STAT_OFS),
    .EN_OFS   (EN_OFS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .clr_vec   (clr_vec)
  );

  usb_irq_out u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_q (stat_q),
    .en_q   (en_q),
    .irq    (irq)
  );
endmodule

// File: rtl/usb_irq_chk.sv
module usb_irq_chk
  import usb_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              device_mode,
  input logic              ev_xact_err,
  input logic              ev_err_resume,
  input logic [STAT_W-1:0] set_vec,
  input logic [STAT_W-1:0] clr_vec,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] en_q,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq
);
  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & en_q) != '0) |=> irq); // R1

  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & en_q) == '0) |=> !irq); // R11

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat_q) & ~$past(clr_vec) & ~stat_q) == '0)); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr_vec) & ~$past(set_vec) & stat_q) == '0)); // R3

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> (($past(set_vec) & ~stat_q) == '0)); // R10

  AST_DEV_ERR_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (device_mode && ev_xact_err && !ev_err_resume) |-> !set_vec[B_ERR]); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:STAT_W] == '0); // R8
endmodule

bind usb_irq_ctrl usb_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .device_mode   (device_mode),
  .ev_xact_err   (ev_xact_err),
  .ev_err_resume (ev_err_resume),
  .set_vec       (set_vec),
  .clr_vec       (clr_vec),
  .stat_q        (stat_q),
  .en_q          (en_q),
  .bus_rdata     (bus_rdata),
  .irq           (irq)
);

// File: tb/usb_irq_ctrl_bench.sv
module usb_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_STAT = 8'h00;
  localparam logic [7:0] A_EN   = 8'h04;

  // {expected status[8:0], events[11:0]}; event bits from 0 upward:
  // done, ioc, short, err, resume, port, frame, syserr, async, busrst, sof, device_mode
  localparam int NVEC = 16;
  localparam logic [20:0] VEC [NVEC] = '{
    {9'h000, 12'h001}, {9'h001, 12'h003}, {9'h001, 12'h004}, {9'h002, 12'h008},
    {9'h003, 12'h00A}, {9'h000, 12'h808}, {9'h002, 12'h818}, {9'h003, 12'h81A},
    {9'h004, 12'h020}, {9'h008, 12'h040}, {9'h010, 12'h080}, {9'h020, 12'h100},
    {9'h040, 12'h200}, {9'h080, 12'h400}, {9'h000, 12'h80A}, {9'h001, 12'h807}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic device_mode = 1'b0;
  logic ev_xfer_done = 1'b0, ev_ioc = 1'b0, ev_short_pkt = 1'b0, ev_xact_err = 1'b0;
  logic ev_err_resume = 1'b0, ev_port_chg = 1'b0, ev_frame_roll = 1'b0, ev_sys_err = 1'b0;
  logic ev_async_adv = 1'b0, ev_bus_reset = 1'b0, ev_sof = 1'b0, suspend_state = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int  n_chk = 0;
  int  n_err = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_ctrl u_usb_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .device_mode(device_mode),
    .ev_xfer_done(ev_xfer_done), .ev_ioc(ev_ioc), .ev_short_pkt(ev_short_pkt),
    .ev_xact_err(ev_xact_err), .ev_err_resume(ev_err_resume),
    .ev_port_chg(ev_port_chg), .ev_frame_roll(ev_frame_roll), .ev_sys_err(ev_sys_err),
    .ev_async_adv(ev_async_adv), .ev_bus_reset(ev_bus_reset), .ev_sof(ev_sof),
    .suspend_state(suspend_state), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_ev(input logic [11:0] v);
    ev_xfer_done = v[0];  ev_ioc = v[1];        ev_short_pkt = v[2];
    ev_xact_err = v[3];   ev_err_resume = v[4]; ev_port_chg = v[5];
    ev_frame_roll = v[6]; ev_sys_err = v[7];    ev_async_adv = v[8];
    ev_bus_reset = v[9];  ev_sof = v[10];       device_mode = v[11];
  endtask

  // Drive at a falling edge, one rising edge, return at the next falling edge.
  task automatic pulse(input logic [11:0] v);
    @(negedge clk); drive_ev(v);
    @(negedge clk); drive_ev('0);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // Combinational read, sampled at a falling edge; consumes no clock edge.
  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    bus_read(A_STAT, rd); check("R3 status after reset", rd, 32'h0);
    bus_read(A_EN, rd);   check("R8 enable after reset", rd, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    // Table walk: event mapping with all enables off
    for (int i = 0; i < NVEC; i++) begin
      bus_write(A_STAT, 32'h1FF);
      pulse(VEC[i][11:0]);
      bus_read(A_STAT, rd);
      check($sformatf("R4/R5/R6/R7/R12 vector %0d", i), rd, {23'b0, VEC[i][20:12]});
    end
    bus_write(A_STAT, 32'h1FF);

    // R8: reserved enable bits
    bus_write(A_EN, 32'hFFFF_FFFF);
    bus_read(A_EN, rd); check("R8 enable reserved bits", rd, 32'h1FF);
    bus_write(A_EN, 32'h0);

    // R2: polling with enable off
    pulse(12'h020);
    bus_read(A_STAT, rd); check("R2 polled status", rd, 32'h004);
    @(negedge clk); check("R2 irq stays low", {31'b0, irq}, 32'h0);

    // R3: writing zero keeps, writing one clears
    bus_write(A_STAT, 32'hFFFF_FE00);
    bus_read(A_STAT, rd); check("R3 write zero keeps bit", rd, 32'h004);
    bus_write(A_STAT, 32'h004);
    bus_read(A_STAT, rd); check("R3 write one clears", rd, 32'h0);

    // R1 / R11: irq lag on rise and on clear
    bus_write(A_EN, 32'h004);
    pulse(12'h020);
    check("R1 irq one edge after status", {31'b0, irq}, 32'h0);
    @(negedge clk); check("R1 irq high", {31'b0, irq}, 32'h1);
    bus_write(A_STAT, 32'h004);
    check("R11 irq holds at clear edge", {31'b0, irq}, 32'h1);
    @(negedge clk); check("R11 irq low after clear", {31'b0, irq}, 32'h0);

    // R11: removing the enable
    pulse(12'h020);
    @(negedge clk); check("R1 irq high again", {31'b0, irq}, 32'h1);
    bus_write(A_EN, 32'h0);
    check("R11 irq holds at disable edge", {31'b0, irq}, 32'h1);
    @(negedge clk); check("R11 irq low after disable", {31'b0, irq}, 32'h0);
    bus_read(A_STAT, rd); check("R2 status kept after disable", rd, 32'h004);

    // R10: event and clear in the same cycle
    @(negedge clk);
    drive_ev(12'h020);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h004;
    @(negedge clk);
    drive_ev('0); bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    bus_read(A_STAT, rd); check("R10 event beats clear", rd, 32'h004);
    bus_write(A_STAT, 32'h1FF);

    // R9: both suspend transitions, sleep interrupt
    bus_write(A_EN, 32'h100);
    @(negedge clk); suspend_state = 1'b1;
    @(negedge clk);
    bus_read(A_STAT, rd); check("R9 rise sets sleep bit", rd, 32'h100);
    @(negedge clk); check("R9 sleep irq", {31'b0, irq}, 32'h1);
    bus_write(A_STAT, 32'h100);
    repeat (2) @(negedge clk);
    bus_read(A_STAT, rd); check("R9 steady suspend sets nothing", rd, 32'h0);
    check("R11 sleep irq cleared", {31'b0, irq}, 32'h0);
    suspend_state = 1'b0;
    @(negedge clk);
    bus_read(A_STAT, rd); check("R9 fall sets sleep bit", rd, 32'h100);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule